// File: doc/BRIEF.md
# Deserializer Output State Controller

This block sits between the recovered parallel video of a serial-link receiver and its output pins. It decides, cycle by cycle, whether the colour bus, the three sync/enable lines and the pixel clock pin float, are pulled to a forced low, carry recovered data, or (for the clock pin only) carry a local oscillator clock. It also produces the link-lock status pin and the pass status pin. High-impedance is represented as an output-enable per pin group plus a data value, so the surrounding pad ring builds the actual tri-state buffers.

A hold-low mode keeps every video pin low after power-up until the host releases it. A strap selects this mode, and the block samples the strap on the release of power-down. Only a host write pulse on the hold toggle bit releases the hold, and only while the link is locked. The hold arms again automatically when lock is lost. The host can also arm it by hand with another write while locked. When the hold mode is strapped on, the float-when-unlocked option is overridden. An oscillator-select field decides whether the clock pin carries the oscillator while the link has no lock.

Top module: `vid_out_gate`

## Requirements
- R1: While power-down is asserted (`pwrDnN` low, registered once), the video, clock and pass pin groups have their enables at 0 and `lockOut` is 0.
- R2: `holdStrap` is sampled only on the cycle where `pwrDnN` goes from 0 to 1. Changes to it before that edge or after it do not affect the hold mode.
- R3: When the hold is armed, `pixOut`, `hsOut`, `vsOut`, `deOut` and `pclkOut` are driven low with their enables at 1, whatever the recovered inputs are.
- R4: `lockOut` equals the `lockRaw` input delayed by a two-flop synchroniser, and the hold mode never changes it.
- R5: A one-cycle pulse on `holdTglWr` while the synchronised lock is 1 releases an armed hold. A pulse while lock is 0 is ignored.
- R6: When the hold mode is strapped on, each falling edge of the synchronised lock arms the hold again. The hold stays armed after lock returns.
- R7: When the hold mode is strapped on and the hold is released, a `holdTglWr` pulse while locked arms the hold again.
- R8: When the hold mode is strapped on, `stateSel` is ignored. Unlocked outputs are driven low with their enables at 1.
- R9: When powered up, unlocked and not floating, with `oscSel` nonzero, `pclkOut` follows `oscClk`. Video is driven low and `passOut` is 0 with `passOe` at 1.
- R10: When powered up, unlocked and not floating, with `oscSel` equal to 0, `pclkOut` is driven low with `pclkOe` at 1.
- R11: When locked and the hold is not armed, `pixOut`, `hsOut`, `vsOut` and `deOut` equal their inputs, `pclkOut` follows `pclkIn`, and `passOut` is 1.
- R12: When the hold mode is not strapped on, `stateSel` is 1 and the link is unlocked, all three pin-group enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Power-down, active low |
| lockRaw | input | 1 | Unsynchronised link lock indication |
| holdStrap | input | 1 | Hold-low mode strap |
| holdTglWr | input | 1 | One-cycle host write pulse to the hold toggle bit |
| stateSel | input | 1 | 1: float outputs while unlocked |
| oscSel | input | OSC_SEL_W | Oscillator select, nonzero enables the oscillator on the clock pin |
| oscClk | input | 1 | Local oscillator clock |
| pixIn | input | PIX_W | Recovered colour bits |
| hsIn | input | 1 | Recovered horizontal sync |
| vsIn | input | 1 | Recovered vertical sync |
| deIn | input | 1 | Recovered data enable |
| pclkIn | input | 1 | Recovered pixel clock |
| pixOut | output | PIX_W | Colour pin values |
| hsOut | output | 1 | Horizontal sync pin value |
| vsOut | output | 1 | Vertical sync pin value |
| deOut | output | 1 | Data enable pin value |
| vidOe | output | 1 | Enable for colour, sync and data enable pins |
| pclkOut | output | 1 | Pixel clock pin value |
| pclkOe | output | 1 | Pixel clock pin enable |
| passOut | output | 1 | Pass pin value |
| passOe | output | 1 | Pass pin enable |
| lockOut | output | 1 | Lock status pin, always driven |

## Verification
The bench builds the block with its default parameters: three 8-bit colour channels, a 3-bit oscillator select and a two-stage lock synchroniser. The full 24-bit bus then carries patterns that set every channel at once, so a forced low cannot be mistaken for a recovered zero. Because the synchroniser is two stages deep, the checker can compare `lockOut` against the raw lock from exactly two cycles earlier. The 3-bit select gives both a zero and a nonzero setting, which covers the oscillator branch and the driven-low branch of the clock pin.

// File: rtl/vog_pkg.sv
package vog_pkg;
  typedef enum logic [1:0] {PCK_LOW = 2'd0, PCK_OSC = 2'd1, PCK_REC = 2'd2} pclkSrc_e;

  typedef struct packed {
    logic     vidOe;
    logic     vidPass;
    logic     pclkOe;
    pclkSrc_e pclkSrc;
    logic     passOe;
    logic     passVal;
    logic     lockVal;
  } outStrb_t;
endpackage

// File: rtl/vog_sync.sv
module vog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vog_ctrl.sv
module vog_ctrl
  import vog_pkg::*;
#(
  parameter int OSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 lockRaw,
  input  logic                 holdStrap,
  input  logic                 holdTglWr,
  input  logic                 stateSel,
  input  logic [OSC_SEL_W-1:0] oscSel,
  output outStrb_t             strb
);
  logic pdQ, lockS, lockQ, holdEn, holdArm;
  logic pdRise, lockFall, oscOn, floatUnlocked;

  vog_sync #(.STAGES(SYNC_STAGES)) u_lockSync (
    .clk(clk), .rstN(rstN), .d(lockRaw), .q(lockS)
  );

  assign pdRise        = pwrDnN & ~pdQ;
  assign lockFall      = lockQ & ~lockS;
  assign oscOn         = |oscSel;
  assign floatUnlocked = stateSel & ~holdEn;

  // power-down edge, lock edge history, strap capture and hold arm state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdQ     <= 1'b0;
      lockQ   <= 1'b0;
      holdEn  <= 1'b0;
      holdArm <= 1'b0;
    end else begin
      pdQ   <= pwrDnN;
      lockQ <= lockS;
      if (!pwrDnN) begin
        holdEn  <= 1'b0;
        holdArm <= 1'b0;
      end else if (pdRise) begin
        holdEn  <= holdStrap;
        holdArm <= holdStrap;
      end else if (holdEn && lockFall) begin
        holdArm <= 1'b1;
      end else if (holdEn && holdTglWr && lockS) begin
        holdArm <= ~holdArm;
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.pclkSrc = PCK_LOW;
    if (pdQ) begin
      strb.lockVal = lockS;
      if (holdArm) begin
        strb.vidOe   = 1'b1;
        strb.pclkOe  = 1'b1;
        strb.passOe  = 1'b1;
        strb.passVal = lockS;
      end else if (lockS) begin
        strb.vidOe   = 1'b1;
        strb.vidPass = 1'b1;
        strb.pclkOe  = 1'b1;
        strb.pclkSrc = PCK_REC;
        strb.passOe  = 1'b1;
        strb.passVal = 1'b1;
      end else if (!floatUnlocked) begin
        strb.vidOe   = 1'b1;
        strb.pclkOe  = 1'b1;
        strb.pclkSrc = oscOn ? PCK_OSC : PCK_LOW;
        strb.passOe  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vog_datapath.sv
module vog_datapath
  import vog_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int N_CH = 3,
  localparam int PIX_W = CH_W * N_CH
) (
  input  outStrb_t          strb,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic              hsIn,
  input  logic              vsIn,
  input  logic              deIn,
  input  logic              pclkIn,
  input  logic              oscClk,
  output logic [PIX_W-1:0]  pixOut,
  output logic              hsOut,
  output logic              vsOut,
  output logic              deOut,
  output logic              vidOe,
  output logic              pclkOut,
  output logic              pclkOe,
  output logic              passOut,
  output logic              passOe,
  output logic              lockOut
);
  logic gateOpen;
  assign gateOpen = strb.vidOe & strb.vidPass;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
      assign pixOut[c*CH_W +: CH_W] = gateOpen ? pixIn[c*CH_W +: CH_W] : '0;
    end
  endgenerate

  assign hsOut = gateOpen & hsIn;
  assign vsOut = gateOpen & vsIn;
  assign deOut = gateOpen & deIn;
  assign vidOe = strb.vidOe;

  always_comb begin
    case (strb.pclkSrc)
      PCK_OSC: pclkOut = oscClk;
      PCK_REC: pclkOut = pclkIn;
      default: pclkOut = 1'b0;
    endcase
  end

  assign pclkOe  = strb.pclkOe;
  assign passOut = strb.passVal;
  assign passOe  = strb.passOe;
  assign lockOut = strb.lockVal;
endmodule

// File: rtl/vid_out_gate.sv
module vid_out_gate
  import vog_pkg::*;
#(
  parameter int CH_W        = 8,
  parameter int N_CH        = 3,
  parameter int OSC_SEL_W   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PIX_W      = CH_W * N_CH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 lockRaw,
  input  logic                 holdStrap,
  input  logic                 holdTglWr,
  input  logic                 stateSel,
  input  logic [OSC_SEL_W-1:0] oscSel,
  input  logic                 oscClk,
  input  logic [PIX_W-1:0]     pixIn,
  input  logic                 hsIn,
  input  logic                 vsIn,
  input  logic                 deIn,
  input  logic                 pclkIn,
  output logic [PIX_W-1:0]     pixOut,
  output logic                 hsOut,
  output logic                 vsOut,
  output logic                 deOut,
  output logic                 vidOe,
  output logic                 pclkOut,
  output logic                 pclkOe,
  output logic                 passOut,
  output logic                 passOe,
  output logic                 lockOut
);
  outStrb_t strb;

  vog_ctrl #(.OSC_SEL_W(OSC_SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .lockRaw(lockRaw),
    .holdStrap(holdStrap), .holdTglWr(holdTglWr), .stateSel(stateSel),
    .oscSel(oscSel), .strb(strb)
  );

  vog_datapath #(.CH_W(CH_W), .N_CH(N_CH)) u_dp (
    .strb(strb), .pixIn(pixIn), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .pclkIn(pclkIn), .oscClk(oscClk), .pixOut(pixOut), .hsOut(hsOut),
    .vsOut(vsOut), .deOut(deOut), .vidOe(vidOe), .pclkOut(pclkOut),
    .pclkOe(pclkOe), .passOut(passOut), .passOe(passOe), .lockOut(lockOut)
  );
endmodule

// File: rtl/vid_out_gate_chk.sv
module vid_out_gate_chk #(
  parameter int PIX_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrDnN,
  input logic             lockRaw,
  input logic [PIX_W-1:0] pixIn,
  input logic [PIX_W-1:0] pixOut,
  input logic             hsOut,
  input logic             vsOut,
  input logic             deOut,
  input logic             vidOe,
  input logic             pclkOe,
  input logic             passOe,
  input logic             lockOut
);
  // R1: registered power-down floats every group and clears lock
  assert_pd_float_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pwrDnN) |-> (!vidOe && !pclkOe && !passOe && !lockOut));

  // R9: driven video while unlocked is always low
  assert_unlocked_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vidOe && !lockOut) |-> (pixOut == '0 && !hsOut && !vsOut && !deOut));

  // R11: nonzero colour on the pins is never anything but the recovered value
  assert_no_corrupt_R11: assert property (@(posedge clk) disable iff (!rstN)
    (vidOe && (pixOut != '0)) |-> (pixOut == pixIn && lockOut));

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R4: lock pin is the raw lock two cycles late, never masked by hold
      assert_lock_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
        $past(pwrDnN) |-> (lockOut == $past(lockRaw, 2)));
    end
  endgenerate
endmodule

bind vid_out_gate vid_out_gate_chk #(.PIX_W(PIX_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .lockRaw(lockRaw), .pixIn(pixIn),
  .pixOut(pixOut), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut), .vidOe(vidOe),
  .pclkOe(pclkOe), .passOe(passOe), .lockOut(lockOut)
);

// File: tb/sim_vid_out_gate.sv
`timescale 1ns/1ps
module sim_vid_out_gate;
  localparam int PIX_W = 24;

  logic clk = 1'b0, oscClk = 1'b0, pclkIn = 1'b0;
  logic rstN, pwrDnN, lockRaw, holdStrap, holdTglWr, stateSel;
  logic [2:0] oscSel;
  logic [PIX_W-1:0] pixIn, pixOut;
  logic hsIn, vsIn, deIn, hsOut, vsOut, deOut, vidOe, pclkOut, pclkOe;
  logic passOut, passOe, lockOut;
  int testCnt = 0, failCnt = 0;

  always #2.5 clk = ~clk;
  always #3.5 oscClk = ~oscClk;
  always #4.5 pclkIn = ~pclkIn;

  vid_out_gate u0 (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .lockRaw(lockRaw),
    .holdStrap(holdStrap), .holdTglWr(holdTglWr), .stateSel(stateSel),
    .oscSel(oscSel), .oscClk(oscClk), .pixIn(pixIn), .hsIn(hsIn), .vsIn(vsIn),
    .deIn(deIn), .pclkIn(pclkIn), .pixOut(pixOut), .hsOut(hsOut), .vsOut(vsOut),
    .deOut(deOut), .vidOe(vidOe), .pclkOut(pclkOut), .pclkOe(pclkOe),
    .passOut(passOut), .passOe(passOe), .lockOut(lockOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTgl;
    @(negedge clk) holdTglWr = 1'b1;
    @(negedge clk) holdTglWr = 1'b0;
    waitCyc(2);
  endtask

  task automatic setLock(input logic v);
    @(negedge clk) lockRaw = v;
    waitCyc(4);
  endtask

  task automatic checkHeld(input string req);
    chk(vidOe && pclkOe && pixOut == '0 && !hsOut && !vsOut && !deOut && !pclkOut,
        req, {vidOe, pclkOe, pclkOut, hsOut, vsOut, deOut, pixOut}, {2'b11, 4'b0, 24'h0});
  endtask

  task automatic checkPass(input string req);
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #0.7;
      if (pclkOut !== pclkIn) ok = 1'b0;
    end
    chk(vidOe && pixOut == pixIn && hsOut == hsIn && vsOut == vsIn && deOut == deIn
        && passOut && passOe && ok, req, {ok, passOut, pixOut}, {2'b11, pixIn});
  endtask

  task automatic powerUp(input logic strap);
    @(negedge clk) pwrDnN = 1'b0; holdStrap = ~strap;
    waitCyc(3);
    holdStrap = strap;
    @(negedge clk) pwrDnN = 1'b1;
    waitCyc(2);
    holdStrap = ~strap;   // R2: later changes must not matter
    waitCyc(2);
  endtask

  task automatic t_powerDown;
    holdStrap = 1'b1;
    waitCyc(3);
    chk(!vidOe && !pclkOe && !passOe && !lockOut, "R1 power-down float",
        {vidOe, pclkOe, passOe, lockOut}, 4'b0);
  endtask

  task automatic t_holdArmed;
    powerUp(1'b1);
    setLock(1'b1);
    checkHeld("R3 hold forces video and clock low");
    chk(lockOut == 1'b1, "R4 lock pin unaffected by hold", lockOut, 1);
    chk(vidOe && pixOut == '0, "R2 strap captured at power-up edge", pixOut, 0);
  endtask

  task automatic t_tglUnlocked;
    setLock(1'b0);
    chk(lockOut == 1'b0, "R4 lock pin follows loss", lockOut, 0);
    pulseTgl();
    setLock(1'b1);
    checkHeld("R5 toggle while unlocked ignored");
  endtask

  task automatic t_release;
    pulseTgl();
    checkPass("R5 toggle while locked releases");
  endtask

  task automatic t_manualRearm;
    pulseTgl();
    checkHeld("R7 manual re-arm while locked");
    pulseTgl();
    checkPass("R7 second toggle releases again");
  endtask

  task automatic t_autoRearm;
    stateSel = 1'b1;
    setLock(1'b0);
    chk(vidOe && pclkOe && passOe && pixOut == '0, "R8 state select ignored under hold",
        {vidOe, pclkOe, passOe}, 3'b111);
    setLock(1'b1);
    checkHeld("R6 lock fall re-arms hold");
    stateSel = 1'b0;
    pulseTgl();
  endtask

  task automatic t_oscillator;
    bit ok = 1'b1;
    powerUp(1'b0);
    setLock(1'b1);
    checkPass("R2 strap raised after power-up has no effect");
    oscSel = 3'd3;
    setLock(1'b0);
    for (int i = 0; i < 8; i++) begin
      #0.9;
      if (pclkOut !== oscClk) ok = 1'b0;
    end
    chk(ok && pclkOe && vidOe && pixOut == '0 && passOe && !passOut,
        "R9 oscillator on clock pin while unlocked", {ok, pclkOe, passOut}, 3'b110);
    oscSel = 3'd0;
    waitCyc(2);
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #0.9;
      if (pclkOut !== 1'b0) ok = 1'b0;
    end
    chk(ok && pclkOe, "R10 clock pin low when oscillator off", {ok, pclkOe}, 2'b11);
  endtask

  task automatic t_floatSel;
    stateSel = 1'b1;
    waitCyc(2);
    chk(!vidOe && !pclkOe && !passOe, "R12 float while unlocked",
        {vidOe, pclkOe, passOe}, 3'b0);
    pixIn = 24'h0F1E2D; hsIn = 1'b0; vsIn = 1'b1; deIn = 1'b0;
    setLock(1'b1);
    checkPass("R11 locked pass-through");
  endtask

  task automatic t_powerDownAgain;
    @(negedge clk) pwrDnN = 1'b0;
    waitCyc(2);
    chk(!vidOe && !pclkOe && !passOe && !lockOut, "R1 re-entry to power-down",
        {vidOe, pclkOe, passOe, lockOut}, 4'b0);
  endtask

  initial begin
    #500000;
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; pwrDnN = 1'b0; lockRaw = 1'b0; holdStrap = 1'b0; holdTglWr = 1'b0;
    stateSel = 1'b0; oscSel = 3'd0;
    pixIn = 24'hA5C35A; hsIn = 1'b1; vsIn = 1'b0; deIn = 1'b1;
    waitCyc(4);
    chk(!vidOe && !pclkOe && !passOe && !lockOut, "R1 reset state",
        {vidOe, pclkOe, passOe, lockOut}, 4'b0);
    rstN = 1'b1;
    t_powerDown();
    t_holdArmed();
    t_tglUnlocked();
    t_release();
    t_manualRearm();
    t_autoRearm();
    t_oscillator();
    t_floatSel();
    t_powerDownAgain();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule